// File: doc/BRIEF.md
# Serial Register Window Slave

This block is the host-facing serial port of a radio data decoder. It is a four-wire serial slave. One 64-bit shift register exposes eight byte-wide registers. When chip select falls, the shift register is loaded with a snapshot of all eight registers. After that, each serial clock moves one bit out and takes one bit in. When chip select rises, the last two bytes received may be written into the two registers the host is allowed to write. Whether they are written depends on a gate bit in the final byte.

The block also owns the interrupt register. It holds a three-bit event source selector, an interrupt flag that clears when it is read, and a resync request that reads back as zero. An active-low interrupt pin follows the flag, so the host can poll the first byte or wait for the pin. The serial pins are asynchronous to the system clock and are resynchronized inside the block. The contents of the data, quality and correction registers come in as plain inputs from the decoder core.

Top module: `serial_reg_window`

## Requirements
- R1: After reset, `ctrl_o` is 0x01, `src_o` is 0, `resync_o` is 0 and `irq_n_o` is 1.
- R2: A falling `spi_cs_n_i` snapshots the window. The window is sent MSB first, one bit per serial clock, in this order: interrupt byte, quality, correction, data low, data high, control, filter, test. `spi_miso_o` moves on the falling serial clock edge, and `spi_mosi_i` is sampled on the rising edge.
- R3: The interrupt byte has the following bits:
  - bit 0: the flag
  - bits 3:1: the source code
  - bit 4: `sync_i`
  - bits 7:5: read as 0. Bit 5 is the resync request, and it always reads as zero.
- R4: On a rising chip select, if bit 7 of the last byte received is 1, then `src_o` takes bits 3:1 of that byte. `ctrl_o` takes bits 7:1 of the byte before it, and `ctrl_o` bit 0 stays 1.
- R5: If bit 7 of the last byte received is 0, neither `ctrl_o` nor `src_o` changes.
- R6: A committed last byte with bit 5 set gives a `resync_o` pulse of exactly one system clock. An uncommitted byte gives none.
- R7: Source codes 0 and 7 select no event. A code k from 1 to 6 selects `evt_i[k-1]`, where `evt_i[0]` is "new block". Each selected event pulse sets the flag.
- R8: `irq_n_o` is the inverse of the flag.
- R9: The flag clears at the 8th rising serial clock of a transfer. A transfer of fewer bits leaves it set.
- R10: An event that arrives after chip select fell is not lost when the read clears the flag.
- R11: Transfers may have any length. Byte positions not received in a transfer count as zero: an 8-bit commit writes control 0x01. For a transfer longer than 16 bits, only the last two bytes matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck_i | input | 1 | Serial clock, asynchronous |
| spi_cs_n_i | input | 1 | Chip select, active low, asynchronous |
| spi_mosi_i | input | 1 | Serial data in |
| spi_miso_o | output | 1 | Serial data out |
| irq_n_o | output | 1 | Interrupt, active low |
| evt_i | input | 6 | Event pulses from the decoder core |
| sync_i | input | 1 | Decoder synchronized status |
| qual_i | input | 8 | Quality register contents |
| corr_i | input | 8 | Correction register contents |
| dlo_i | input | 8 | Data low byte |
| dhi_i | input | 8 | Data high byte |
| filt_i | input | 8 | Filter settings register |
| test_i | input | 8 | Test register |
| ctrl_o | output | 8 | Control register |
| src_o | output | 3 | Interrupt source code |
| resync_o | output | 1 | One-cycle resync request |

## Verification
Full 64-bit reads are repeated with four different register patterns and alternating sync status. This separates byte order from bit order and shows whether the snapshot is live.

Every source code is crossed with every event line. This sets the flag only on the one matching pair and shows that codes 0 and 7 are silent.

Transfers of 4, 8, 16 and 72 bits tell apart three things: partial reads, the last-two-bytes rule, and zero fill. Events injected in the middle of a transfer show whether clear-on-read can lose a new event.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CTRL_RST = 8'h01;
  localparam int INT_GATE_BIT   = 7;
  localparam int INT_RESYNC_BIT = 5;
  localparam int INT_SYNC_BIT   = 4;
  localparam int INT_SRC_LSB    = 1;
  localparam int INT_FLAG_BIT   = 0;

  // Window layout, first field leaves first (MSB first)
  typedef struct packed {
    logic [BYTE_W-1:0] intr;
    logic [BYTE_W-1:0] qual;
    logic [BYTE_W-1:0] corr;
    logic [BYTE_W-1:0] dlo;
    logic [BYTE_W-1:0] dhi;
    logic [BYTE_W-1:0] ctrl;
    logic [BYTE_W-1:0] filt;
    logic [BYTE_W-1:0] test;
  } win_t;
endpackage

// File: rtl/srw_sync.sv
module srw_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff_q <= {STAGES{RST_VAL[b]}};
      else        ff_q <= {ff_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = ff_q[STAGES-1];
  end
endmodule

// File: rtl/srw_shift.sv
module srw_shift #(
  parameter int WIN_W  = 64,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_s,
  input  logic                sck_s,
  input  logic                mosi_s,
  input  logic [WIN_W-1:0]    load_i,
  output logic                miso_o,
  output logic                cs_fall_o,
  output logic                cs_rise_o,
  output logic                sck_fall_o,
  output logic                rd_done_o,
  output logic [2*BYTE_W-1:0] rx_o
);
  localparam int RX_W  = 2 * BYTE_W;
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic              sck_q, cs_q;
  logic [WIN_W-1:0]  tx_q, tx_n;
  logic [RX_W-1:0]   rx_q, rx_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              sck_rise;

  assign sck_rise   = sck_s & ~sck_q & ~cs_s;
  assign sck_fall_o = ~sck_s & sck_q & ~cs_s;
  assign cs_fall_o  = cs_q & ~cs_s;
  assign cs_rise_o  = ~cs_q & cs_s;
  assign rd_done_o  = sck_rise && (cnt_q == CNT_W'(BYTE_W - 1));
  assign miso_o     = tx_q[WIN_W-1];
  assign rx_o       = rx_q;

  always_comb begin
    tx_n  = tx_q;
    rx_n  = rx_q;
    cnt_n = cnt_q;
    if (cs_fall_o) begin
      tx_n  = load_i;
      rx_n  = '0;
      cnt_n = '0;
    end else begin
      if (sck_rise) begin
        rx_n = {rx_q[RX_W-2:0], mosi_s};
        if (cnt_q != CNT_W'(BYTE_W)) cnt_n = cnt_q + 1'b1;
      end
      if (sck_fall_o) tx_n = {tx_q[WIN_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      tx_q  <= '0;
      rx_q  <= '0;
      cnt_q <= '0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
      tx_q  <= tx_n;
      rx_q  <= rx_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/srw_regs.sv
module srw_regs
  import srw_pkg::*;
#(
  parameter int NSRC  = 6,
  parameter int SRC_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_fall_i,
  input  logic                cs_rise_i,
  input  logic                rd_done_i,
  input  logic [2*BYTE_W-1:0] rx_i,
  input  logic [NSRC-1:0]     evt_i,
  input  logic                sync_i,
  output logic [BYTE_W-1:0]   ctrl_o,
  output logic [SRC_W-1:0]    src_o,
  output logic                flag_o,
  output logic                resync_o,
  output logic                hit_o,
  output logic [BYTE_W-1:0]   int_o
);
  logic [BYTE_W-1:0] ctrl_q, ctrl_n;
  logic [SRC_W-1:0]  src_q, src_n;
  logic              flag_q, flag_n;
  logic              pend_q, pend_n;
  logic              rsy_q, rsy_n;
  logic              commit;

  always_comb begin
    hit_o = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (src_q == SRC_W'(k + 1)) hit_o = hit_o | evt_i[k];
  end

  assign commit = cs_rise_i & rx_i[INT_GATE_BIT];

  always_comb begin
    ctrl_n = ctrl_q;
    src_n  = src_q;
    rsy_n  = 1'b0;
    flag_n = flag_q;
    pend_n = pend_q;
    if (commit) begin
      src_n  = rx_i[INT_SRC_LSB +: SRC_W];
      ctrl_n = rx_i[2*BYTE_W-1:BYTE_W] | CTRL_RST;
      rsy_n  = rx_i[INT_RESYNC_BIT];
    end
    if (cs_fall_i)  pend_n = hit_o;
    else if (hit_o) pend_n = 1'b1;
    if (hit_o)          flag_n = 1'b1;
    else if (rd_done_i) flag_n = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      src_q  <= '0;
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      rsy_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      src_q  <= src_n;
      flag_q <= flag_n;
      pend_q <= pend_n;
      rsy_q  <= rsy_n;
    end
  end

  always_comb begin
    int_o = '0;
    int_o[INT_SYNC_BIT] = sync_i;
    int_o[INT_SRC_LSB +: SRC_W] = src_q;
    int_o[INT_FLAG_BIT] = flag_q;
  end

  assign ctrl_o   = ctrl_q;
  assign src_o    = src_q;
  assign flag_o   = flag_q;
  assign resync_o = rsy_q;
endmodule

// File: rtl/serial_reg_window.sv
module serial_reg_window
  import srw_pkg::*;
#(
  parameter int NSRC  = 6,
  parameter int SRC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck_i,
  input  logic              spi_cs_n_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              irq_n_o,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              sync_i,
  input  logic [7:0]        qual_i,
  input  logic [7:0]        corr_i,
  input  logic [7:0]        dlo_i,
  input  logic [7:0]        dhi_i,
  input  logic [7:0]        filt_i,
  input  logic [7:0]        test_i,
  output logic [7:0]        ctrl_o,
  output logic [SRC_W-1:0]  src_o,
  output logic              resync_o
);
  localparam int WIN_W = $bits(win_t);

  logic [2:0]          pins_s;
  logic                cs_s, sck_s, mosi_s;
  logic                cs_fall, cs_rise, sck_fall, rd_done, evt_hit, flag;
  logic [2*BYTE_W-1:0] rx_last;
  logic [BYTE_W-1:0]   int_byte;
  win_t                win;

  srw_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({spi_cs_n_i, spi_sck_i, spi_mosi_i}), .q_o(pins_s)
  );
  assign {cs_s, sck_s, mosi_s} = pins_s;

  assign win = '{intr: int_byte, qual: qual_i, corr: corr_i, dlo: dlo_i,
                 dhi: dhi_i, ctrl: ctrl_o, filt: filt_i, test: test_i};

  srw_shift #(.WIN_W(WIN_W), .BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_s(sck_s), .mosi_s(mosi_s),
    .load_i(win), .miso_o(spi_miso_o), .cs_fall_o(cs_fall),
    .cs_rise_o(cs_rise), .sck_fall_o(sck_fall), .rd_done_o(rd_done),
    .rx_o(rx_last)
  );

  srw_regs #(.NSRC(NSRC), .SRC_W(SRC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .rd_done_i(rd_done), .rx_i(rx_last), .evt_i(evt_i), .sync_i(sync_i),
    .ctrl_o(ctrl_o), .src_o(src_o), .flag_o(flag), .resync_o(resync_o),
    .hit_o(evt_hit), .int_o(int_byte)
  );

  assign irq_n_o = ~flag;
endmodule

// File: rtl/srw_chk.sv
module srw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        spi_miso_o,
  input logic        irq_n_o,
  input logic        resync_o,
  input logic [7:0]  ctrl_o,
  input logic [2:0]  src_o,
  input logic        sck_fall,
  input logic        cs_fall,
  input logic        cs_rise,
  input logic        rd_done,
  input logic        evt_hit,
  input logic [15:0] rx_last
);
  assert_miso_moves_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_miso_o) |-> $past(sck_fall || cs_fall));

  assert_ctrl_only_on_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> $past(cs_rise && rx_last[7]));

  assert_src_only_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_o) |-> $past(cs_rise && rx_last[7]));

  assert_resync_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resync_o |-> $past(cs_rise && rx_last[7] && rx_last[5]));

  assert_resync_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resync_o |=> !resync_o);

  assert_irq_set_by_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n_o) |-> $past(evt_hit));

  assert_irq_clear_by_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n_o) |-> $past(rd_done));
endmodule

bind serial_reg_window srw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .spi_miso_o(spi_miso_o), .irq_n_o(irq_n_o),
  .resync_o(resync_o), .ctrl_o(ctrl_o), .src_o(src_o), .sck_fall(sck_fall),
  .cs_fall(cs_fall), .cs_rise(cs_rise), .rd_done(rd_done),
  .evt_hit(evt_hit), .rx_last(rx_last)
);

// File: tb/serial_reg_window_bench.sv
`timescale 1ns/1ps
module serial_reg_window_bench;
  localparam int H = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, irq_n, resync, sync_v = 1'b0;
  logic [5:0] evt = '0;
  logic [7:0] qual = '0, corr = '0, dlo = '0, dhi = '0, filt = '0, test = '0;
  logic [7:0] ctrl;
  logic [2:0] src;

  int errors = 0, checks = 0, rs_cnt = 0;
  logic [7:0] ctrl_exp = 8'h01;
  logic [2:0] src_exp = 3'd0;
  logic [127:0] got;

  always #5 clk = ~clk;

  serial_reg_window u_serial_reg_window (
    .clk(clk), .rst_n(rst_n), .spi_sck_i(sck), .spi_cs_n_i(cs_n),
    .spi_mosi_i(mosi), .spi_miso_o(miso), .irq_n_o(irq_n), .evt_i(evt),
    .sync_i(sync_v), .qual_i(qual), .corr_i(corr), .dlo_i(dlo), .dhi_i(dhi),
    .filt_i(filt), .test_i(test), .ctrl_o(ctrl), .src_o(src),
    .resync_o(resync)
  );

  always @(posedge clk) if (resync) rs_cnt <= rs_cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int line);
    waitc(1);
    evt[line] = 1'b1;
    waitc(1);
    evt = '0;
    waitc(5);
  endtask

  // bit i (0 = first) of the transfer sits at din[nb-1-i]
  task automatic xfer(input int nb, input logic [127:0] din,
                      output logic [127:0] dout, input int ev_at = -1);
    dout = '0;
    cs_n = 1'b0;
    waitc(H);
    for (int i = 0; i < nb; i++) begin
      mosi = din[nb-1-i];
      if (i == ev_at) begin
        evt[0] = 1'b1; waitc(1); evt = '0;
      end
      waitc(H);
      dout[nb-1-i] = miso;
      sck = 1'b1;
      waitc(H);
      sck = 1'b0;
    end
    waitc(H);
    cs_n = 1'b1;
    waitc(H);
  endtask

  function automatic logic [7:0] int_exp(input logic f);
    return {3'b000, sync_v, src_exp, f};
  endfunction

  initial begin
    waitc(200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    // R1 reset state
    chk(ctrl == 8'h01, "R1 ctrl", ctrl, 8'h01);
    chk(src == 3'd0, "R1 src", src, 0);
    chk(irq_n == 1'b1 && resync == 1'b0, "R1 irq/resync", {irq_n, resync}, 2'b10);

    // R2 R3 full window reads with distinct patterns
    for (int p = 0; p < 4; p++) begin
      logic [63:0] e;
      qual = 8'h11 * (p + 1); corr = 8'hA5 ^ 8'(p * 29); dlo = 8'(p * 53 + 7);
      dhi = ~dlo; filt = 8'h3C + 8'(p); test = 8'h80 >> p; sync_v = p[0];
      e = {int_exp(1'b0), qual, corr, dlo, dhi, ctrl_exp, filt, test};
      xfer(64, '0, got);
      chk(got[63:0] == e, "R2 R3 window read", got[63:0], e);
    end

    // R4 R7 R8 R9 R3: every source code against every event line
    for (int code = 0; code < 8; code++) begin
      logic [7:0] cw;
      cw = 8'h5A ^ 8'(code * 37);
      xfer(16, {112'h0, cw, 1'b1, 3'b000, 3'(code), 1'b0}, got);
      ctrl_exp = cw | 8'h01; src_exp = 3'(code);
      chk(ctrl == ctrl_exp, "R4 ctrl commit", ctrl, ctrl_exp);
      chk(src == src_exp, "R4 src commit", src, src_exp);
      for (int line = 0; line < 6; line++) begin
        bit hit;
        hit = (code >= 1 && code <= 6 && line == code - 1);
        pulse(line);
        chk(irq_n == !hit, "R7 R8 event select", irq_n, !hit);
        if (hit) begin
          xfer(8, '0, got);
          chk(got[7:0] == int_exp(1'b1), "R3 flag in int byte", got[7:0], int_exp(1'b1));
          chk(irq_n == 1'b1, "R9 clear after 8 bits", irq_n, 1);
        end
      end
    end

    // R5 R6: gate bit low, resync bit set -> nothing happens
    begin
      int rs0;
      rs0 = rs_cnt;
      xfer(16, {112'h0, 8'hFE, 8'h7F}, got);
      chk(ctrl == ctrl_exp && src == src_exp, "R5 no commit", {ctrl, src}, {ctrl_exp, src_exp});
      chk(rs_cnt == rs0, "R6 no pulse without commit", rs_cnt, rs0);
      // R6 committed resync
      xfer(16, {112'h0, ctrl_exp, 8'b1010_0010}, got);
      src_exp = 3'd1;
      chk(rs_cnt == rs0 + 1, "R6 single pulse", rs_cnt, rs0 + 1);
      xfer(8, '0, got);
      chk(got[7:0] == int_exp(1'b0), "R3 resync reads zero", got[7:0], int_exp(1'b0));
    end

    // R9 partial read keeps flag
    pulse(0);
    chk(irq_n == 1'b0, "R8 irq asserted", irq_n, 0);
    xfer(4, '0, got);
    chk(irq_n == 1'b0, "R9 short read keeps flag", irq_n, 0);
    xfer(8, '0, got);
    chk(irq_n == 1'b1, "R9 full byte clears", irq_n, 1);

    // R10 event during read survives the clear
    pulse(0);
    xfer(8, '0, got, 3);
    chk(got[7:0] == int_exp(1'b1), "R10 snapshot flag", got[7:0], int_exp(1'b1));
    chk(irq_n == 1'b0, "R10 new event kept", irq_n, 0);
    xfer(8, '0, got);
    chk(irq_n == 1'b1, "R10 later clear", irq_n, 1);

    // R11 8-bit commit: missing control byte counts as zero
    xfer(8, {120'h0, 8'b1000_0110}, got);
    ctrl_exp = 8'h01; src_exp = 3'd3;
    chk(ctrl == ctrl_exp && src == src_exp, "R11 short commit", {ctrl, src}, {ctrl_exp, src_exp});
    // R11 72-bit transfer: only last two bytes count
    xfer(72, {56'h0, 56'hFF_FFFF_FFFF_FFFF, 8'hC4, 8'b1000_1010}, got);
    ctrl_exp = 8'hC5; src_exp = 3'd5;
    chk(ctrl == ctrl_exp && src == src_exp, "R11 long commit", {ctrl, src}, {ctrl_exp, src_exp});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule